// File: doc/BRIEF.md
# Simultaneous-Sampling Converter Result Sequencer

This block is a clocked timing model of the digital side of an eight-lane, 14-bit converter that samples all of its lanes at the same instant. A rising edge on the start-of-conversion input freezes the per-lane sample values that the environment supplies. The block then counts a fixed conversion latency and hands out one result per active lane, starting at lane 0. Every result is marked by a one-clock low pulse on an active-low end-of-conversion strobe. A second active-low strobe goes low with the final lane's result and stays low until the next accepted start.

Results are read through a parallel port. The port is modelled as a 14-bit data value together with an output-enable flag, not as a true tri-state net. The flag is high only while both the active-low select and the active-low read inputs are low. Select may be held low all the time, pulsed only around reads, or wired to read; all three ways of using it behave the same.

Top module: `sseq_result_seq`

## Requirements
- R1: After reset, `eoc_n_o` and `eolc_n_o` are high and the sequencer stays idle, with no end-of-conversion pulse, until the first rising edge of `start_i`; a reset in the middle of a sequence abandons it and returns both strobes high.
- R2: The sample values on `samples_i` (lane k at bits [14k+13:14k]) are captured at the clock edge that accepts the start, and later changes on `samples_i` do not alter that sequence's results.
- R3: If `start_i` is sampled high at edge E0 after being sampled low at the edge before it, while the block is idle, then the first `eoc_n_o` low appears after edge E0+17.
- R4: Result k (k = 0 upward) is flagged by `eoc_n_o` low after edge E0+17+3k and carries the captured value of lane k; exactly N results are produced.
- R5: `eoc_n_o` stays low for exactly one clock per result and is high in every other cycle.
- R6: `eolc_n_o` goes low together with the last result's `eoc_n_o` pulse and stays low until the edge that accepts the next start, where it returns high.
- R7: `nchan_i` is an unsigned lane count N read at the accepting edge; 0 is treated as 1 and any value above 8 is treated as 8.
- R8: A rising edge of `start_i` that arrives while a sequence is running is ignored, so neither the timing nor the data of the running sequence changes.
- R9: `dout_oe_o` is 1 exactly when `sel_n_i` and `rd_n_i` are both 0, and `dout_o` then shows the most recent result; otherwise `dout_oe_o` is 0 and `dout_o` is 0. This holds with select held low, pulsed only around reads, or tied to read.
- R10: Only a rising edge starts a conversion: holding `start_i` high after a sequence ends starts no second sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start of conversion; a rising edge starts one conversion |
| sel_n_i | input | 1 | Active-low chip select for the result port |
| rd_n_i | input | 1 | Active-low read strobe |
| nchan_i | input | 4 | Number of active lanes, 1 to 8 |
| samples_i | input | 112 | Per-lane sample values, lane k at bits [14k+13:14k] |
| eoc_n_o | output | 1 | Active-low end-of-conversion pulse, one per result |
| eolc_n_o | output | 1 | Active-low end-of-last-conversion level |
| dout_o | output | 14 | Result data, 0 while the port is released |
| dout_oe_o | output | 1 | Result port drive enable |

## Verification
The bench names the clock edge that accepts a start E0. It then counts posedges and samples every output on the falling edge that follows each one. An end-of-conversion pulse is due only after edges E0+17, E0+20 and so on, up to E0+17+3(N-1); the bench demands a low strobe there and a high strobe in every other cycle. The end-of-last-conversion level is due from E0+17+3(N-1) and must persist until the next E0. The data port is combinational from select and read, so a port check is sampled a nanosecond after those inputs change, with no clock in between.

// File: rtl/sseq_pkg.sv
`timescale 1ns/1ps
package sseq_pkg;
    localparam int SSEQ_NCH       = 8;
    localparam int SSEQ_DW        = 14;
    localparam int SSEQ_FIRST_LAT = 17;
    localparam int SSEQ_CADENCE   = 3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } sseq_state_e;

    typedef struct packed {
        logic accept;
        logic emit;
    } sseq_evt_t;

    // Index of the final lane for a requested count, clamped to [1, nch].
    function automatic int unsigned last_index(input int unsigned req,
                                               input int unsigned nch);
        if (req == 0)  return 0;
        if (req > nch) return nch - 1;
        return req - 1;
    endfunction
endpackage

// File: rtl/sseq_timer.sv
`timescale 1ns/1ps
module sseq_timer
    import sseq_pkg::*;
#(
    parameter int NCH       = SSEQ_NCH,
    parameter int FIRST_LAT = SSEQ_FIRST_LAT,
    parameter int CADENCE   = SSEQ_CADENCE,
    parameter int CH_W      = $clog2(NCH),
    parameter int NC_W      = $clog2(NCH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [NC_W-1:0] nchan_i,
    output sseq_evt_t       evt_o,
    output logic [CH_W-1:0] ch_o,
    output logic            eoc_n_o,
    output logic            eolc_n_o
);
    localparam int CNT_MAX = (FIRST_LAT > CADENCE) ? FIRST_LAT : CADENCE;
    localparam int CNT_W   = $clog2(CNT_MAX);

    sseq_state_e      state_q;
    logic             conv_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CH_W-1:0]  ch_q;
    logic [CH_W-1:0]  last_q;
    logic             accept;
    logic             emit;

    assign accept = start_i && !conv_q && (state_q == ST_IDLE);
    assign emit   = (state_q == ST_BUSY) && (cnt_q == '0);
    assign evt_o  = '{accept: accept, emit: emit};
    assign ch_o   = ch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            conv_q   <= 1'b0;
            cnt_q    <= '0;
            ch_q     <= '0;
            last_q   <= '0;
            eoc_n_o  <= 1'b1;
            eolc_n_o <= 1'b1;
        end else begin
            conv_q  <= start_i;
            eoc_n_o <= 1'b1;
            if (accept) begin
                state_q  <= ST_BUSY;
                cnt_q    <= CNT_W'(FIRST_LAT - 1);
                ch_q     <= '0;
                last_q   <= CH_W'(last_index(int'(nchan_i), NCH));
                eolc_n_o <= 1'b1;
            end else if (state_q == ST_BUSY) begin
                if (emit) begin
                    eoc_n_o <= 1'b0;
                    if (ch_q == last_q) begin
                        state_q  <= ST_IDLE;
                        eolc_n_o <= 1'b0;
                    end else begin
                        ch_q  <= ch_q + 1'b1;
                        cnt_q <= CNT_W'(CADENCE - 1);
                    end
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    AST_EOC_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        !eoc_n_o |=> eoc_n_o); // R5
    AST_EOC_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        !eoc_n_o |-> $past(state_q == ST_BUSY)); // R3
    AST_EOLC_WITH_EOC: assert property (@(posedge clk) disable iff (rst)
        $fell(eolc_n_o) |-> !eoc_n_o); // R6
    AST_EOLC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!eolc_n_o && !accept) |=> !eolc_n_o); // R6
    AST_CH_BOUND: assert property (@(posedge clk) disable iff (rst)
        ch_q <= last_q); // R4
endmodule

// File: rtl/sseq_hold.sv
`timescale 1ns/1ps
module sseq_hold
    import sseq_pkg::*;
#(
    parameter int NCH  = SSEQ_NCH,
    parameter int DW   = SSEQ_DW,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  sseq_evt_t         evt_i,
    input  logic [CH_W-1:0]   ch_i,
    input  logic [NCH*DW-1:0] samples_i,
    output logic [DW-1:0]     result_o
);
    logic [DW-1:0] lane_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)               lane_q[g] <= '0;
            else if (evt_i.accept) lane_q[g] <= samples_i[g*DW +: DW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             result_o <= '0;
        else if (evt_i.emit) result_o <= lane_q[ch_i];
    end

    AST_RESULT_STEADY: assert property (@(posedge clk) disable iff (rst)
        !evt_i.emit |=> $stable(result_o)); // R9
endmodule

// File: rtl/sseq_bus.sv
`timescale 1ns/1ps
module sseq_bus
    import sseq_pkg::*;
#(
    parameter int DW = SSEQ_DW
) (
    input  logic          sel_n_i,
    input  logic          rd_n_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] data_o,
    output logic          oe_o
);
    always_comb begin
        oe_o   = !sel_n_i && !rd_n_i;
        data_o = oe_o ? data_i : '0;
    end
endmodule

// File: rtl/sseq_result_seq.sv
`timescale 1ns/1ps
module sseq_result_seq
    import sseq_pkg::*;
#(
    parameter int NCH       = SSEQ_NCH,
    parameter int DW        = SSEQ_DW,
    parameter int FIRST_LAT = SSEQ_FIRST_LAT,
    parameter int CADENCE   = SSEQ_CADENCE,
    localparam int CH_W     = $clog2(NCH),
    localparam int NC_W     = $clog2(NCH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              sel_n_i,
    input  logic              rd_n_i,
    input  logic [NC_W-1:0]   nchan_i,
    input  logic [NCH*DW-1:0] samples_i,
    output logic              eoc_n_o,
    output logic              eolc_n_o,
    output logic [DW-1:0]     dout_o,
    output logic              dout_oe_o
);
    sseq_evt_t       evt;
    logic [CH_W-1:0] ch;
    logic [DW-1:0]   result;

    sseq_timer #(
        .NCH(NCH), .FIRST_LAT(FIRST_LAT), .CADENCE(CADENCE),
        .CH_W(CH_W), .NC_W(NC_W)
    ) u_timer (
        .clk(clk), .rst(rst), .start_i(start_i), .nchan_i(nchan_i),
        .evt_o(evt), .ch_o(ch), .eoc_n_o(eoc_n_o), .eolc_n_o(eolc_n_o)
    );

    sseq_hold #(.NCH(NCH), .DW(DW), .CH_W(CH_W)) u_hold (
        .clk(clk), .rst(rst), .evt_i(evt), .ch_i(ch),
        .samples_i(samples_i), .result_o(result)
    );

    sseq_bus #(.DW(DW)) u_bus (
        .sel_n_i(sel_n_i), .rd_n_i(rd_n_i), .data_i(result),
        .data_o(dout_o), .oe_o(dout_oe_o)
    );

    AST_PORT_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (sel_n_i || rd_n_i) |-> (!dout_oe_o && dout_o == '0)); // R9
endmodule

// File: tb/test_sseq_result_seq.sv
`timescale 1ns/1ps
module test_sseq_result_seq;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         sel_n_i = 1'b1;
    logic         rd_n_i = 1'b1;
    logic [3:0]   nchan_i = 4'd1;
    logic [111:0] samples_i = '0;
    logic         eoc_n_o, eolc_n_o, dout_oe_o;
    logic [13:0]  dout_o;

    int checks = 0;
    int failures = 0;
    logic [13:0] cur_exp = '0;
    logic        eolc_exp = 1'b1;

    always #10 clk = ~clk;

    sseq_result_seq i_sseq_result_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .sel_n_i(sel_n_i),
        .rd_n_i(rd_n_i), .nchan_i(nchan_i), .samples_i(samples_i),
        .eoc_n_o(eoc_n_o), .eolc_n_o(eolc_n_o),
        .dout_o(dout_o), .dout_oe_o(dout_oe_o)
    );

    // fields: [15:12] requested count, [11:4] seed, [1] scramble samples, [0] retrigger
    localparam logic [15:0] VEC [8] = '{
        16'h1_13_0, 16'h2_2A_2, 16'h3_05_0, 16'h8_77_2,
        16'h0_41_0, 16'hC_9C_0, 16'h5_E3_1, 16'h4_18_3
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [13:0] samp(input int seed, input int ch);
        return 14'(seed * 2731 + ch * 613 + 1);
    endfunction

    task automatic run_conv(input int nreq, input int seed, input bit retrig,
                            input bit scramble);
        int neff;
        logic [13:0] exp_s [8];
        neff = (nreq == 0) ? 1 : ((nreq > 8) ? 8 : nreq);
        for (int ch = 0; ch < 8; ch++) begin
            exp_s[ch] = samp(seed, ch);
            samples_i[ch*14 +: 14] = exp_s[ch];
        end
        nchan_i = 4'(nreq);
        sel_n_i = 1'b0;
        rd_n_i  = 1'b0;
        @(negedge clk);
        chk(eolc_n_o === eolc_exp, "R6 eolc held before start", eolc_n_o, eolc_exp);
        start_i = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
        eolc_exp = 1'b1;
        chk(eolc_n_o === 1'b1, "R6 eolc released at accept", eolc_n_o, 1);
        chk(eoc_n_o === 1'b1, "R5 eoc idle at accept", eoc_n_o, 1);
        for (int t = 1; t <= 44; t++) begin
            bit is_eoc;
            int k;
            if (scramble && t == 2) samples_i = ~samples_i;
            if (retrig && t == 6) start_i = 1'b1;
            if (retrig && t == 8) start_i = 1'b0;
            @(negedge clk);
            k = (t - 17) / 3;
            is_eoc = (t >= 17) && ((t - 17) % 3 == 0) && (k < neff);
            if (is_eoc) cur_exp = exp_s[k];
            if (t >= 17 + 3 * (neff - 1)) eolc_exp = 1'b0;
            chk(eoc_n_o === !is_eoc, (t == 17) ? "R3 first eoc" :
                (retrig ? "R8 eoc timing" : "R4/R5 eoc cadence"), eoc_n_o, !is_eoc);
            chk(eolc_n_o === eolc_exp, "R6 eolc level", eolc_n_o, eolc_exp);
            if (t >= 17)
                chk(dout_o === cur_exp && dout_oe_o === 1'b1,
                    scramble ? "R2 captured data" : (nreq != neff ? "R7 clamp data" : "R4 lane data"),
                    dout_o, cur_exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(eoc_n_o === 1'b1 && eolc_n_o === 1'b1, "R1 strobes in reset", {eoc_n_o, eolc_n_o}, 3);
        @(negedge clk);
        rst = 1'b0;
        // R1: idle until the first start edge
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            chk(eoc_n_o === 1'b1 && eolc_n_o === 1'b1, "R1 idle after reset",
                {eoc_n_o, eolc_n_o}, 3);
        end

        for (int v = 0; v < 8; v++)
            run_conv(int'(VEC[v][15:12]), int'(VEC[v][11:4]), VEC[v][0], VEC[v][1]);

        // R9: port qualification with select and read
        sel_n_i = 1'b1; rd_n_i = 1'b0; #1;
        chk(dout_oe_o === 1'b0 && dout_o === 14'd0, "R9 select high releases", dout_o, 0);
        sel_n_i = 1'b0; rd_n_i = 1'b1; #1;
        chk(dout_oe_o === 1'b0 && dout_o === 14'd0, "R9 read high releases", dout_o, 0);
        sel_n_i = 1'b1; rd_n_i = 1'b1; #1;
        chk(dout_oe_o === 1'b0, "R9 both high released", dout_oe_o, 0);
        sel_n_i = 1'b0; rd_n_i = 1'b0; #1;
        chk(dout_oe_o === 1'b1 && dout_o === cur_exp, "R9 tied select and read drive", dout_o, cur_exp);
        sel_n_i = 1'b0; rd_n_i = 1'b1; #1;
        rd_n_i = 1'b0; #1;
        chk(dout_o === cur_exp, "R9 select held low read pulse", dout_o, cur_exp);

        // R10: start held high produces exactly one sequence
        begin
            int seen;
            seen = 0;
            nchan_i = 4'd2;
            @(negedge clk);
            start_i = 1'b1;
            for (int i = 0; i < 80; i++) begin
                @(negedge clk);
                if (eoc_n_o === 1'b0) seen++;
            end
            chk(seen == 2, "R10 level start gives one sequence", seen, 2);
            chk(eolc_n_o === 1'b0, "R10 eolc stays low with start held", eolc_n_o, 0);
            start_i = 1'b0;
        end

        // R1: reset in the middle of a sequence
        @(negedge clk);
        start_i = 1'b1;
        nchan_i = 4'd8;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(eolc_n_o === 1'b1 && eoc_n_o === 1'b1, "R1 reset abandons sequence",
            {eoc_n_o, eolc_n_o}, 3);
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (eoc_n_o === 1'b0) seen++;
            end
            chk(seen == 0, "R1 no results after reset", seen, 0);
        end
        chk(dout_o === 14'd0, "R1 result cleared by reset", dout_o, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule